// File: doc/BRIEF.md
# Parallel Word Scrambler with NRZI Encoding

This block takes one 20-bit parallel video word per pixel clock (74.25 MHz or 74.25/1.001 MHz), scrambles it with a self-synchronizing scrambler of polynomial x^9 + x^4 + 1, and then applies NRZI encoding of the form x + 1. Both steps are fully unrolled, so a whole word is handled in one clock. Bit 0 of each word is treated as the first bit in serial order. The 9-bit scrambler history and the 1-bit NRZI level carry over from one word to the next, so the output equals what a bit-serial encoder would produce on the concatenated stream.

A run-time bypass input passes words through untouched. A separate clear input clears the encoder state on its low-to-high transition only; its level has no effect. The output is registered, so bypassed and encoded words see the same one-cycle latency. The block serves as the last parallel stage ahead of a serializer.

Top module: `hd_scrambler_nrzi`

## Requirements
- R1: `dout` shows the result for the word on `din` one clock after that word is sampled, both in bypass and in encode mode.
- R2: When `bypass` is 1, `dout` equals the `din` sampled on the previous clock, bit for bit.
- R3: When `bypass` is 0, each bit i (from 0 up to 19) gives a scrambled bit s = din[i] XOR s(4 bits earlier) XOR s(9 bits earlier), where "earlier" counts in serial order across word boundaries.
- R4: The NRZI output bit is n = s XOR n(previous bit). dout[i] carries n for bit i, and the NRZI level after bit 19 is the starting level for the next word.
- R5: The last 9 scrambled bits of a word (bits 11 to 19) form the scrambler history for the next encoded word.
- R6: A clock where `clr` is sampled 1 and was sampled 0 on the clock before is a clear event. The word in that cycle is encoded with the state that existed before the event. The next word starts from all-zero scrambler history and NRZI level 0.
- R7: Holding `clr` at 1 or at 0 over several clocks causes no further clearing.
- R8: While `bypass` is 1, the scrambler history and the NRZI level keep their values unless a clear event occurs. Encoding then resumes as if the bypassed words had not been present.
- R9: `rst_n` low at a clock edge sets `dout` to 0, clears the encoder state, and treats `clr` as previously 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 20 | Parallel input word, bit 0 first in serial order |
| bypass | input | 1 | 1 = pass the word through, 0 = scramble and NRZI encode |
| clr | input | 1 | Encoder clear, acts on its rising edge |
| dout | output | 20 | Registered output word |

## Verification
The bench compares every word against a bit-serial model that uses a 9-stage shift register. A design that got the tap positions or the bit order wrong would start to differ on the first non-zero word. Long runs of encoded words test the carry of history and NRZI level across word boundaries; a design that dropped the carry would differ only from the second word on. Bypass runs placed between encoded runs expose a design that keeps advancing its state while bypassed. A `clr` held high over several words exposes a design that clears on the level instead of the edge, and a clear in the middle of a stream exposes one that clears a cycle early or a cycle late.

// File: rtl/hdsn_pkg.sv
// Package: default geometry shared by the scrambler/NRZI block and its checker.
package hdsn_pkg;
    localparam int DEF_WORD_W  = 20;  // bits per parallel word
    localparam int DEF_SCR_LEN = 9;   // scrambler polynomial degree
    localparam int DEF_SCR_TAP = 4;   // inner tap of the scrambler polynomial
endpackage

// File: rtl/hdsn_rise_detect.sv
// Rising-edge detector for the clear input.
// Assumes the input is already synchronous to clk. Reset treats the previous value as 0.
module hdsn_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    // Keep the value sampled on the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/hdsn_scr_unroll.sv
// Unrolled self-synchronizing scrambler, x^LEN + x^TAP + 1, W bits per call.
// Bit 0 is the earliest bit in serial order. hist_i[0] is the oldest scrambled bit
// and hist_i[LEN-1] the newest. Assumes W >= LEN.
module hdsn_scr_unroll #(
    parameter int W   = 20,
    parameter int LEN = 9,
    parameter int TAP = 4
) (
    input  logic [LEN-1:0] hist_i,
    input  logic [W-1:0]   d,
    output logic [W-1:0]   s,
    output logic [LEN-1:0] hist_o
);
    localparam int EXT_W = LEN + W;

    logic [EXT_W-1:0] ext;

    // Extend the history with each new scrambled bit, oldest to newest.
    always_comb begin
        ext = '0;
        ext[LEN-1:0] = hist_i;
        for (int i = 0; i < W; i++) begin
            ext[LEN+i] = d[i] ^ ext[LEN+i-TAP] ^ ext[i];
        end
    end

    assign s      = ext[EXT_W-1:LEN];
    assign hist_o = ext[EXT_W-1:W];
endmodule

// File: rtl/hdsn_nrzi_unroll.sv
// Unrolled NRZI encoder (x + 1): each output bit is its input XOR the previous output bit.
// lvl_i is the level after the previous word. lvl_o is the level after bit W-1.
module hdsn_nrzi_unroll #(
    parameter int W = 20
) (
    input  logic         lvl_i,
    input  logic [W-1:0] s,
    output logic [W-1:0] n,
    output logic         lvl_o
);
    logic acc;

    // Running XOR along the word in serial order.
    always_comb begin
        acc = lvl_i;
        n   = '0;
        for (int i = 0; i < W; i++) begin
            acc  = acc ^ s[i];
            n[i] = acc;
        end
    end

    assign lvl_o = n[W-1];
endmodule

// File: rtl/hd_scrambler_nrzi.sv
// Parallel scrambler followed by NRZI, one word per clock, with registered output.
// The state advances only on encoded words. A rising edge of clr zeroes the state
// for the following word. Assumes all inputs are synchronous to clk.
module hd_scrambler_nrzi #(
    parameter int WORD_W  = hdsn_pkg::DEF_WORD_W,
    parameter int SCR_LEN = hdsn_pkg::DEF_SCR_LEN,
    parameter int SCR_TAP = hdsn_pkg::DEF_SCR_TAP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic              bypass,
    input  logic              clr,
    output logic [WORD_W-1:0] dout
);
    logic [SCR_LEN-1:0] hist_q, hist_nx;
    logic               nrzi_q, nrzi_nx;
    logic [WORD_W-1:0]  scr_w, enc_w, dout_q;
    logic               clr_rise;

    hdsn_rise_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (clr),
        .rise  (clr_rise)
    );

    hdsn_scr_unroll #(.W(WORD_W), .LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
        .hist_i (hist_q),
        .d      (din),
        .s      (scr_w),
        .hist_o (hist_nx)
    );

    hdsn_nrzi_unroll #(.W(WORD_W)) u_nrzi (
        .lvl_i (nrzi_q),
        .s     (scr_w),
        .n     (enc_w),
        .lvl_o (nrzi_nx)
    );

    // Register the output word and update the encoder state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            hist_q <= '0;
            nrzi_q <= 1'b0;
        end else begin
            dout_q <= bypass ? din : enc_w;
            if (clr_rise) begin
                hist_q <= '0;
                nrzi_q <= 1'b0;
            end else if (!bypass) begin
                hist_q <= hist_nx;
                nrzi_q <= nrzi_nx;
            end
        end
    end

    assign dout = dout_q;
endmodule

// File: rtl/hdsn_chk.sv
// Checker for hd_scrambler_nrzi. It relates the ports to the encoder state.
module hdsn_chk #(
    parameter int W = 20,
    parameter int L = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] din,
    input logic         bypass,
    input logic         clr,
    input logic [W-1:0] dout,
    input logic [L-1:0] hist,
    input logic         nrzi
);
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (dout == $past(din)));                                   // R2
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && din == '0 && hist == '0 && !nrzi && !clr) |=> (dout == '0)); // R3
    AST_NRZI_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !clr) |=> (nrzi == dout[W-1]));                         // R4
    AST_HIST_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !clr) |=> (hist == (dout[W-1:W-L] ^ dout[W-2:W-L-1]))); // R5
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !$past(clr) && $past(rst_n)) |=> (hist == '0 && !nrzi));   // R6
    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !clr) |=> ($stable(hist) && $stable(nrzi)));             // R8
    AST_RESET_OUT: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));                                           // R9
endmodule

bind hd_scrambler_nrzi hdsn_chk #(.W(WORD_W), .L(SCR_LEN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .bypass (bypass),
    .clr    (clr),
    .dout   (dout),
    .hist   (hist_q),
    .nrzi   (nrzi_q)
);

// File: tb/sim_hd_scrambler_nrzi.sv
module sim_hd_scrambler_nrzi;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] din = '0;
    logic        bypass = 1'b0;
    logic        clr = 1'b0;
    logic [19:0] dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bit-serial reference state: sr[0] is the newest scrambled bit.
    logic [8:0] m_sr = '0;
    logic       m_lvl = 1'b0;
    logic       m_clr_prev = 1'b0;

    always #4 clk = ~clk;

    hd_scrambler_nrzi u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .bypass(bypass), .clr(clr), .dout(dout)
    );

    // {bypass, word}
    localparam logic [20:0] VEC [0:11] = '{
        21'h0_00001, 21'h0_00000, 21'h0_FFFFF, 21'h0_A5A5A,
        21'h1_12345, 21'h0_3FF00, 21'h0_00200, 21'h1_FFFFF,
        21'h0_80001, 21'h0_5555A, 21'h1_00000, 21'h0_C0FFE
    };

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%05h expected=%05h", tag, got, exp);
        end
    endtask

    // Drive one word, advance the model, and compare after the capturing edge.
    task automatic step(input string tag, input logic bp, input logic c, input logic [19:0] d);
        logic [19:0] exp;
        logic [8:0]  sr;
        logic        lv, s;
        @(negedge clk);
        din = d; bypass = bp; clr = c;
        sr = m_sr; lv = m_lvl;
        for (int i = 0; i < 20; i++) begin
            s  = d[i] ^ sr[3] ^ sr[8];
            sr = {sr[7:0], s};
            lv = lv ^ s;
            exp[i] = lv;
        end
        if (bp) exp = d;
        if (c && !m_clr_prev) begin
            m_sr = '0; m_lvl = 1'b0;
        end else if (!bp) begin
            m_sr = sr; m_lvl = lv;
        end
        m_clr_prev = c;
        @(posedge clk);
        #1 check(tag, dout, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clr = 1'b0; bypass = 1'b0; din = '0;
        repeat (2) @(posedge clk);
        #1 check("R9 reset output", dout, '0);
        m_sr = '0; m_lvl = 1'b0; m_clr_prev = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // Table walk: R1 R2 R3 R4 R5 R8 across mixed words.
        for (int k = 0; k < 12; k++) begin
            step("R1/R3/R4/R5 table", VEC[k][20], 1'b0, VEC[k][19:0]);
        end
        // Zero word from zero state stays zero (R3).
        do_reset();
        step("R3 zero in zero state", 1'b0, 1'b0, 20'h00000);
        // Single one at bit 0, then a run of zeros: carried history (R5) and NRZI level (R4).
        step("R3 impulse", 1'b0, 1'b0, 20'h00001);
        for (int k = 0; k < 6; k++) step("R5 history carry", 1'b0, 1'b0, 20'h00000);
        step("R4 level carry", 1'b0, 1'b0, 20'h80000);
        // Bypass run keeps state (R8, R2).
        for (int k = 0; k < 4; k++) step("R2/R8 bypass", 1'b1, 1'b0, 20'h0F0F0 ^ 20'(k));
        for (int k = 0; k < 3; k++) step("R8 resume", 1'b0, 1'b0, 20'h13579 + 20'(k));
        // Clear edge mid-stream (R6), then level held high (R7).
        step("R6 clear edge word", 1'b0, 1'b1, 20'hABCDE);
        step("R6 first word after clear", 1'b0, 1'b1, 20'h00001);
        for (int k = 0; k < 4; k++) step("R7 clr held high", 1'b0, 1'b1, 20'h2468A + 20'(k));
        for (int k = 0; k < 3; k++) step("R7 clr held low", 1'b0, 1'b0, 20'hFEDCB - 20'(k));
        // Second edge while bypassed still clears (R6, R8).
        step("R6 edge in bypass", 1'b1, 1'b1, 20'h77777);
        step("R6 after bypass clear", 1'b0, 1'b0, 20'h00001);
        step("R6 after bypass clear 2", 1'b0, 1'b0, 20'hFFFFF);
        // Reset in mid-stream (R9).
        step("R3 pre-reset", 1'b0, 1'b0, 20'h9ABCD);
        do_reset();
        step("R9 first word after reset", 1'b0, 1'b0, 20'h00001);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule